// File: doc/BRIEF.md
# Initiator-Target Access Partition Checker

This block sits on the request path between bus initiators and bus targets. Initiators are processor cores, groups of DMA channels and other bus masters. Targets are peripheral channel groups, memory areas and control register banks. Each request carries a 4-bit initiator identifier, an address and a read/write flag. The block decodes the address into a target identifier. It then looks up the (initiator, target) pair in a programmable table of 16 rules. The request is either forwarded to the target or refused with an error response.

A multi-channel peripheral can be split into channel groups, and RAM or ROM can be split into areas. Each of these pieces is given its own address window and therefore its own target identifier. One software domain can then own a group exclusively, keep a private memory area, or share an area with other domains by writing one rule per initiator. Software fills the table through a small register port and can seal it with a lock bit that holds until reset. Refused requests raise a sticky violation flag and leave a record of the offending request.

Top module: `acc_part_chk`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, viol_flag is 0, cfg_locked is 0, and every table entry reads back as zero, which means invalid with no permission.
- R2: Address bits [15:11] select a 2 KiB window. Windows 0 to 23 decode to target identifiers 0 to 23. Windows 24 to 31 hit no target, and a request to them is always refused.
- R3: A request is granted only when some entry has valid=1, SRC equal to the initiator, DEST equal to the decoded target, and a permission that covers the operation. A read is covered by permission codes 01 (read) and 11 (read/write). A write is covered only by code 11. Codes 00 and 10 permit nothing. Everything else is refused.
- R4: A request is accepted at a rising edge where req_valid and req_ready are both 1. req_ready is 0 in the cycle that follows. resp_valid is 1 for exactly one cycle, starting at the second edge after acceptance, and req_ready is 1 again in that same cycle.
- R5: With resp_valid high, exactly one of resp_grant and resp_err is 1. A granted response carries the decoded target in resp_tgt and the request's address and read/write flag in resp_addr and resp_wr.
- R6: A refused request sets viol_flag at the same edge that raises resp_valid. The flag stays set until a cycle with viol_clr high. If a refusal and viol_clr occur at the same edge, the flag ends up set.
- R7: cap_src, cap_addr and cap_wr record the first refused request after the flag was clear. Later refusals do not change them while the flag stays set.
- R8: A cfg_we pulse writes cfg_wdata into entry cfg_idx. cfg_rdata shows entry cfg_idx combinationally. The field layout is valid=[11], SRC=[10:7], DEST=[6:2] and permission=[1:0].
- R9: A cfg_lock_set pulse sets cfg_locked, which then stays set until reset. While it is set, cfg_we has no effect on the table.
- R10: Several entries may name the same target for different initiators, which gives a shared area. The rules are evaluated independently, so their position in the table does not matter, and an entry with valid=0 is ignored whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Initiator presents a request |
| req_ready | output | 1 | Checker can accept a request |
| req_src | input | 4 | Initiator identifier |
| req_addr | input | 16 | Request address |
| req_wr | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | Decision pulse |
| resp_grant | output | 1 | Request forwarded to target |
| resp_err | output | 1 | Error response to initiator |
| resp_tgt | output | 5 | Decoded target identifier |
| resp_addr | output | 16 | Forwarded address |
| resp_wr | output | 1 | Forwarded read/write flag |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Table entry index for write and read |
| cfg_wdata | input | 12 | Entry to write |
| cfg_rdata | output | 12 | Entry at cfg_idx |
| cfg_lock_set | input | 1 | Seal the table until reset |
| cfg_locked | output | 1 | Table sealed |
| viol_clr | input | 1 | Clear the violation flag |
| viol_flag | output | 1 | Sticky violation flag |
| cap_src | output | 4 | Captured initiator of first violation |
| cap_addr | output | 16 | Captured address of first violation |
| cap_wr | output | 1 | Captured read/write flag of first violation |

## Verification
The hardest cases are the ones that depend on the whole table at once. Examples are a permission that applies to reads but not to writes, an invalid entry whose other fields would match, and two initiators sharing one target. To reach them, the bench loads a table built from an index formula that covers every permission code, unreachable target values and a shared area. It then sweeps all 16 initiators over all 32 address windows for both reads and writes, alternating between the lowest and highest offset inside each window. The same-edge race between a refusal and a flag clear is set up by raising viol_clr in the cycle between acceptance and response.

// File: rtl/apc_pkg.sv
package apc_pkg;
    localparam int SRC_W  = 4;
    localparam int DEST_W = 5;
    localparam int PERM_W = 2;
    localparam int RULE_W = 1 + SRC_W + DEST_W + PERM_W;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE = 2'b00,
        PERM_RD   = 2'b01,
        PERM_RSV  = 2'b10,
        PERM_RW   = 2'b11
    } perm_e;

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [DEST_W-1:0] dest;
        logic [PERM_W-1:0] perm;
    } rule_t;
endpackage

// File: rtl/apc_tgt_decode.sv
module apc_tgt_decode
    import apc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int N_TGT     = 24,
    parameter int REGION_SH = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEST_W-1:0] tgt,
    output logic              hit
);
    localparam int unsigned WIN = 2 ** REGION_SH;

    logic [N_TGT-1:0] hit_vec;

    for (genvar t = 0; t < N_TGT; t++) begin : g_win
        localparam int unsigned BASE  = t * WIN;
        localparam int unsigned LIMIT = BASE + WIN - 1;
        assign hit_vec[t] = (32'(addr) >= BASE) && (32'(addr) <= LIMIT);
    end

    always_comb begin
        tgt = '0;
        for (int t = 0; t < N_TGT; t++) begin
            if (hit_vec[t]) tgt = DEST_W'(t);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/apc_rule_table.sv
module apc_rule_table
    import apc_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  rule_t                   wr_rule,
    input  logic                    lock_set,
    output rule_t                   rd_rule,
    output logic                    locked,
    output rule_t [N_ENT-1:0]       rules
);
    typedef struct packed {
        rule_t [N_ENT-1:0] ent;
        logic              lock;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !st_q.lock) st_d.ent[idx] = wr_rule;
        if (lock_set) st_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_rule = st_q.ent[idx];
    assign locked  = st_q.lock;
    assign rules   = st_q.ent;

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);
    // R9
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.ent));
endmodule

// File: rtl/apc_matcher.sv
module apc_matcher
    import apc_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  rule_t [N_ENT-1:0]  rules,
    input  logic [SRC_W-1:0]   src,
    input  logic [DEST_W-1:0]  tgt,
    input  logic               tgt_hit,
    input  logic               wr,
    output logic               allow
);
    logic [N_ENT-1:0] match;

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        logic perm_ok;
        assign perm_ok = wr ? (rules[e].perm == PERM_RW) : rules[e].perm[0];
        assign match[e] = rules[e].valid && (rules[e].src == src)
                       && (rules[e].dest == tgt) && perm_ok;
    end

    assign allow = tgt_hit && (|match);
endmodule

// File: rtl/acc_part_chk.sv
module acc_part_chk
    import apc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int N_ENT     = 16,
    parameter int N_TGT     = 24,
    parameter int REGION_SH = 11,
    localparam int IDX_W    = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic              resp_err,
    output logic [DEST_W-1:0] resp_tgt,
    output logic [ADDR_W-1:0] resp_addr,
    output logic              resp_wr,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [RULE_W-1:0] cfg_wdata,
    output logic [RULE_W-1:0] cfg_rdata,
    input  logic              cfg_lock_set,
    output logic              cfg_locked,
    input  logic              viol_clr,
    output logic              viol_flag,
    output logic [SRC_W-1:0]  cap_src,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_wr
);
    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  src;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } stage_t;

    typedef struct packed {
        logic              valid;
        logic              grant;
        logic              err;
        logic [DEST_W-1:0] tgt;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } resp_t;

    typedef struct packed {
        stage_t            stg;
        resp_t             rsp;
        logic              viol;
        logic [SRC_W-1:0]  cap_src;
        logic [ADDR_W-1:0] cap_addr;
        logic              cap_wr;
    } state_t;

    state_t st_d, st_q;

    rule_t [N_ENT-1:0] rules;
    rule_t             rd_rule;
    logic [DEST_W-1:0] dec_tgt;
    logic              dec_hit;
    logic              allow;
    logic              accept;

    apc_rule_table #(.N_ENT(N_ENT)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .idx      (cfg_idx),
        .wr_rule  (rule_t'(cfg_wdata)),
        .lock_set (cfg_lock_set),
        .rd_rule  (rd_rule),
        .locked   (cfg_locked),
        .rules    (rules)
    );

    apc_tgt_decode #(
        .ADDR_W    (ADDR_W),
        .N_TGT     (N_TGT),
        .REGION_SH (REGION_SH)
    ) u_decode (
        .addr (st_q.stg.addr),
        .tgt  (dec_tgt),
        .hit  (dec_hit)
    );

    apc_matcher #(.N_ENT(N_ENT)) u_match (
        .rules   (rules),
        .src     (st_q.stg.src),
        .tgt     (dec_tgt),
        .tgt_hit (dec_hit),
        .wr      (st_q.stg.wr),
        .allow   (allow)
    );

    assign accept = req_valid && !st_q.stg.valid;

    always_comb begin
        st_d           = st_q;
        st_d.rsp.valid = 1'b0;
        st_d.rsp.grant = 1'b0;
        st_d.rsp.err   = 1'b0;

        if (viol_clr) st_d.viol = 1'b0;

        if (st_q.stg.valid) begin
            st_d.stg.valid = 1'b0;
            st_d.rsp.valid = 1'b1;
            st_d.rsp.grant = allow;
            st_d.rsp.err   = !allow;
            st_d.rsp.tgt   = dec_tgt;
            st_d.rsp.addr  = st_q.stg.addr;
            st_d.rsp.wr    = st_q.stg.wr;
            if (!allow) begin
                if (!st_q.viol) begin
                    st_d.cap_src  = st_q.stg.src;
                    st_d.cap_addr = st_q.stg.addr;
                    st_d.cap_wr   = st_q.stg.wr;
                end
                st_d.viol = 1'b1;
            end
        end

        if (accept) begin
            st_d.stg.valid = 1'b1;
            st_d.stg.src   = req_src;
            st_d.stg.addr  = req_addr;
            st_d.stg.wr    = req_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready  = !st_q.stg.valid;
    assign resp_valid = st_q.rsp.valid;
    assign resp_grant = st_q.rsp.grant;
    assign resp_err   = st_q.rsp.err;
    assign resp_tgt   = st_q.rsp.tgt;
    assign resp_addr  = st_q.rsp.addr;
    assign resp_wr    = st_q.rsp.wr;
    assign cfg_rdata  = rd_rule;
    assign viol_flag  = st_q.viol;
    assign cap_src    = st_q.cap_src;
    assign cap_addr   = st_q.cap_addr;
    assign cap_wr     = st_q.cap_wr;

    // R4
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 resp_valid);
    // R4
    resp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);
    // R5
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_grant != resp_err));
    // R2
    grant_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_grant) |-> (32'(resp_tgt) < N_TGT));
    // R6
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !viol_clr) |=> viol_flag);
    // R6
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |-> viol_flag);
    // R7
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !viol_clr) |=> ($stable(cap_src) && $stable(cap_addr) && $stable(cap_wr)));
endmodule

// File: tb/acc_part_chk_tb.sv
`timescale 1ns/1ps
module acc_part_chk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_src = '0;
    logic [15:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        resp_valid, resp_grant, resp_err, resp_wr;
    logic [4:0]  resp_tgt;
    logic [15:0] resp_addr;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [11:0] cfg_wdata = '0;
    logic [11:0] cfg_rdata;
    logic        cfg_lock_set = 1'b0;
    logic        cfg_locked;
    logic        viol_clr = 1'b0;
    logic        viol_flag;
    logic [3:0]  cap_src;
    logic [15:0] cap_addr;
    logic        cap_wr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [11:0] mdl [16];

    always #10 clk = ~clk;

    acc_part_chk u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_addr(req_addr), .req_wr(req_wr),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_err(resp_err),
        .resp_tgt(resp_tgt), .resp_addr(resp_addr), .resp_wr(resp_wr),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_lock_set(cfg_lock_set), .cfg_locked(cfg_locked),
        .viol_clr(viol_clr), .viol_flag(viol_flag),
        .cap_src(cap_src), .cap_addr(cap_addr), .cap_wr(cap_wr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit allow_f(input logic [3:0] s, input logic [15:0] a, input logic w);
        int region;
        bit ok;
        region = int'(a[15:11]);
        ok = 1'b0;
        if (region < 24) begin
            for (int e = 0; e < 16; e++) begin
                if (mdl[e][11] && mdl[e][10:7] == s && int'(mdl[e][6:2]) == region) begin
                    if (w ? (mdl[e][1:0] == 2'b11) : mdl[e][0]) ok = 1'b1;
                end
            end
        end
        return ok;
    endfunction

    task automatic cfg_write(input int idx, input logic [11:0] d, input bit locked_now);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!locked_now) mdl[idx] = d;
        chk("R8/R9 readback", 32'(cfg_rdata), 32'(mdl[idx]));
    endtask

    task automatic do_req(input logic [3:0] s, input logic [15:0] a, input logic w,
                          input bit clr_mid, output bit granted);
        bit exp_ok;
        exp_ok = allow_f(s, a, w);
        @(negedge clk);
        chk("R4 ready idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_src = s; req_addr = a; req_wr = w;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 busy", 32'(req_ready), 0);
        chk("R4 no early resp", 32'(resp_valid), 0);
        viol_clr = clr_mid;
        @(negedge clk);
        viol_clr = 1'b0;
        chk("R4 resp pulse", 32'(resp_valid), 1);
        chk("R4 ready back", 32'(req_ready), 1);
        chk("R3 grant", 32'(resp_grant), 32'(exp_ok));
        chk("R5 err", 32'(resp_err), 32'(!exp_ok));
        if (exp_ok) begin
            chk("R2 tgt", 32'(resp_tgt), 32'(a[15:11]));
            chk("R5 addr", 32'(resp_addr), 32'(a));
            chk("R5 wr", 32'(resp_wr), 32'(w));
        end else begin
            chk("R6 flag set", 32'(viol_flag), 1);
        end
        granted = exp_ok;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit g;
        bit first_seen;
        logic [3:0]  f_src;
        logic [15:0] f_addr;
        logic        f_wr;
        logic [15:0] a;
        for (int e = 0; e < 16; e++) mdl[e] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 resp_valid", 32'(resp_valid), 0);
        chk("R1 viol", 32'(viol_flag), 0);
        chk("R1 locked", 32'(cfg_locked), 0);
        for (int e = 0; e < 16; e++) begin
            cfg_idx = 4'(e);
            #1 chk("R1 entry zero", 32'(cfg_rdata), 0);
        end

        // R3 empty table denies everything; R7 first capture
        do_req(4'd3, 16'h0800, 1'b0, 1'b0, g);
        chk("R7 cap src", 32'(cap_src), 3);
        chk("R7 cap addr", 32'(cap_addr), 32'h0800);
        chk("R7 cap wr", 32'(cap_wr), 0);
        @(negedge clk);
        chk("R4 single pulse", 32'(resp_valid), 0);

        // R8 program table: permissions of every code, unreachable dests, shared target 9 (R10)
        for (int i = 0; i < 16; i++) begin
            logic [11:0] d;
            d[11]   = (i != 5);
            d[10:7] = 4'(i ^ 3);
            d[6:2]  = (i >= 12) ? 5'd9 : 5'((i * 7) % 32);
            d[1:0]  = (i >= 12) ? ((i % 2 == 0) ? 2'b11 : 2'b01) : 2'(i % 4);
            cfg_write(i, d, 1'b0);
        end

        // R6 clear
        @(negedge clk); viol_clr = 1'b1;
        @(negedge clk); viol_clr = 1'b0;
        chk("R6 cleared", 32'(viol_flag), 0);

        // R2 R3 R10 sweep: every initiator x window x direction, both window edges
        first_seen = 1'b0;
        f_src = '0; f_addr = '0; f_wr = 1'b0;
        for (int s = 0; s < 16; s++) begin
            for (int r = 0; r < 32; r++) begin
                for (int w = 0; w < 2; w++) begin
                    a = {5'(r), ((s + r + w) % 2 == 0) ? 11'h000 : 11'h7ff};
                    do_req(4'(s), a, w[0], 1'b0, g);
                    if (!g && !first_seen) begin
                        first_seen = 1'b1;
                        f_src = 4'(s); f_addr = a; f_wr = w[0];
                    end
                end
            end
        end
        // R7 first violation of the sweep retained
        chk("R7 sweep flag", 32'(viol_flag), 1);
        chk("R7 sweep src", 32'(cap_src), 32'(f_src));
        chk("R7 sweep addr", 32'(cap_addr), 32'(f_addr));
        chk("R7 sweep wr", 32'(cap_wr), 32'(f_wr));

        // R6 refusal and clear at the same edge: flag ends set, capture stays old
        do_req(4'd0, 16'hF000, 1'b1, 1'b1, g);
        chk("R6 set beats clear", 32'(viol_flag), 1);
        chk("R7 no recapture", 32'(cap_addr), 32'(f_addr));

        // R9 lock: later writes ignored, table still used
        @(negedge clk); cfg_lock_set = 1'b1;
        @(negedge clk); cfg_lock_set = 1'b0;
        chk("R9 locked", 32'(cfg_locked), 1);
        cfg_write(0, 12'hFFF, 1'b1);
        cfg_write(5, 12'h8FF, 1'b1);
        @(negedge clk);
        chk("R9 still locked", 32'(cfg_locked), 1);
        // entry 12: src 15, dest 9, read/write -> granted write
        do_req(4'd15, {5'd9, 11'h123}, 1'b1, 1'b0, g);
        chk("R10 shared write", 32'(g), 1);
        // entry 13: src 14, dest 9, read only -> write refused
        do_req(4'd14, {5'd9, 11'h010}, 1'b1, 1'b0, g);
        chk("R3 ro write refused", 32'(g), 0);

        // R9 reset releases lock
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int e = 0; e < 16; e++) mdl[e] = '0;
        chk("R9 lock released", 32'(cfg_locked), 0);
        chk("R1 viol after reset", 32'(viol_flag), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule